// File: doc/BRIEF.md
# Multiplexed-Address DRAM Device Model

This block is a synthesizable, clock-sampled model of an asynchronous dynamic RAM chip. Row and column addresses share one narrow address input. The chip is driven by four active-low strobes: row strobe `ras_n`, column strobe `cas_n`, write enable `we_n` and output enable `oe_n`. A falling row strobe opens a row, which copies that row from the storage array into a row buffer. Each falling column strobe then picks one word of the open row. When the row strobe rises, the whole buffer is written back to the array, because opening a row is treated as a destructive read.

The data pin is brought out as a pad triple: `dq_in`, `dq_out` and the drive enable `dq_oe`. The model supports these cycles:
- early and late writes;
- early and late reads;
- page-mode bursts of column cycles under one row strobe;
- row-strobe-only refresh.

Every row has its own retention counter. A sticky error is raised if any row is left unactivated for longer than `RET_LIMIT` clock cycles.

All strobes are sampled on `clk`, so strobe widths and spacings are counted in clock cycles.

Top module: `mpx_dram`

## Requirements
- R1: After a clock edge with `rst` high, `dq_oe` is 0 and `ret_err` is 0.
- R2: On a falling `ras_n`, the row address is taken from `addr[ROW_W-1:0]`. On a falling `cas_n`, the column address is taken from `addr[COL_W-1:0]`. A read returns the word stored at that row and column. `cas_n` must fall at least 3 clock cycles after `ras_n` falls.
- R3: `dq_oe` is 1 only while a row is open and `cas_n` and `oe_n` are low with `we_n` high. The stored word is on `dq_out` within 3 cycles after the later of the `cas_n` and `oe_n` falls, so `oe_n` may fall before `cas_n` (early read) or after it (late read). `dq_oe` stays 0 while `oe_n` is high and returns to 0 within 2 cycles after `cas_n` rises.
- R4: Early write: if `we_n` is already low when `cas_n` falls, the word on `dq_in` at that edge is stored in the selected column.
- R5: Late write: if `we_n` falls while `cas_n` is low, the word on `dq_in` at the `we_n` edge is stored in the column taken at the earlier `cas_n` fall.
- R6: While `ras_n` stays low, every falling `cas_n` selects a new column of the same open row. Reads and writes may be mixed within one such page, and a read sees a write made earlier in the same page.
- R7: When `ras_n` rises, the row buffer is written back to the array. Words written while the row was open are read back in later row cycles, and columns not written keep their values.
- R8: A `ras_n` cycle with no `cas_n` fall never sets `dq_oe`, even with `oe_n` low, and leaves the row's contents intact.
- R9: Activating a row clears that row's retention counter. `ret_err` stays 0 as long as every row is activated at least once every `RET_LIMIT` cycles.
- R10: `ret_err` becomes 1 once any row goes `RET_LIMIT` cycles without activation. It then stays 1 until reset, even after later refreshes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling and state clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Shared row/column address |
| dq_in | input | DATA_W | Data pad input |
| dq_out | output | DATA_W | Data pad output value |
| dq_oe | output | 1 | Data pad drive enable |
| ret_err | output | 1 | Sticky retention-deadline error |

## Verification
Reads are run in two orders:
- Output enable before the column strobe, which checks that data appears once both strobes are low.
- Column strobe first with output enable held high, which checks that the pad stays undriven until enable falls.

Writes are run in two orders as well:
- Write enable low ahead of the column edge, with a full row of distinct bytes.
- Write enable falling inside a column cycle.

Distinct bytes expose any mix-up between the two capture points or any column slip. One page mixes writes and reads of the same column. A later row cycle then rereads every column, which separates a correct write-back from a buffer-only update. Refresh-only cycles with output enable low are interleaved, and a long idle window is timed around the retention limit to show the error both held off and then held sticky.

// File: rtl/mdr_pkg.sv
package mdr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_OPEN = 2'd2
  } bank_st_t;

endpackage

// File: rtl/mdr_strobe_sampler.sv
module mdr_strobe_sampler #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic              ras_q,
  output logic              cas_q,
  output logic              we_q,
  output logic              oe_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] din_q,
  output logic              ras_fall,
  output logic              cas_fall,
  output logic              we_fall
);

  logic ras_p, cas_p, we_p;

  // First stage: bring pins into the clock domain (inactive = high)
  always_ff @(posedge clk) begin
    if (rst) begin
      ras_q  <= 1'b1;
      cas_q  <= 1'b1;
      we_q   <= 1'b1;
      oe_q   <= 1'b1;
      addr_q <= '0;
      din_q  <= '0;
    end else begin
      ras_q  <= ras_n;
      cas_q  <= cas_n;
      we_q   <= we_n;
      oe_q   <= oe_n;
      addr_q <= addr;
      din_q  <= din;
    end
  end

  // Second stage: previous level for edge detection
  always_ff @(posedge clk) begin
    if (rst) begin
      ras_p <= 1'b1;
      cas_p <= 1'b1;
      we_p  <= 1'b1;
    end else begin
      ras_p <= ras_q;
      cas_p <= cas_q;
      we_p  <= we_q;
    end
  end

  assign ras_fall = ras_p & ~ras_q;
  assign cas_fall = cas_p & ~cas_q;
  assign we_fall  = we_p & ~we_q;

endmodule

// File: rtl/mdr_row_store.sv
module mdr_row_store #(
  parameter int ROW_W    = 9,
  parameter int ROW_BITS = 4096
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [ROW_W-1:0]    wr_row,
  input  logic [ROW_BITS-1:0] wr_data,
  input  logic [ROW_W-1:0]    rd_row,
  output logic [ROW_BITS-1:0] rd_data
);

  localparam int ROWS = 1 << ROW_W;

  logic [ROW_BITS-1:0] mem [ROWS];

  // Simple dual-port array with registered read, block-RAM shaped
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_row] <= wr_data;
    rd_data <= mem[rd_row];
  end

endmodule

// File: rtl/mdr_row_buffer.sv
module mdr_row_buffer #(
  parameter int COL_W  = 9,
  parameter int DATA_W = 8
) (
  input  logic                           clk,
  input  logic                           load_en,
  input  logic [(DATA_W<<COL_W)-1:0]     load_data,
  input  logic                           col_wr,
  input  logic [COL_W-1:0]               col,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rword,
  output logic [(DATA_W<<COL_W)-1:0]     row_data
);

  localparam int ROW_BITS = DATA_W << COL_W;

  logic [ROW_BITS-1:0] buf_q;

  always_ff @(posedge clk) begin
    if (load_en)
      buf_q <= load_data;
    else if (col_wr)
      buf_q[int'(col)*DATA_W +: DATA_W] <= wdata;
  end

  assign rword    = buf_q[int'(col)*DATA_W +: DATA_W];
  assign row_data = buf_q;

endmodule

// File: rtl/mdr_retention.sv
module mdr_retention #(
  parameter int ROW_W     = 9,
  parameter int RET_LIMIT = 64000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic [ROW_W-1:0] clr_row,
  output logic             err
);

  localparam int ROWS  = 1 << ROW_W;
  localparam int CNT_W = $clog2(RET_LIMIT + 1);
  localparam logic [CNT_W-1:0] LIM = CNT_W'(RET_LIMIT);

  logic [ROWS-1:0] expired;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    logic [CNT_W-1:0] age;
    always_ff @(posedge clk) begin
      if (rst || (clr_en && clr_row == ROW_W'(i)))
        age <= '0;
      else if (age != LIM)
        age <= age + 1'b1;
    end
    assign expired[i] = (age == LIM);
  end

  always_ff @(posedge clk) begin
    if (rst)           err <= 1'b0;
    else if (|expired) err <= 1'b1;
  end

  // R10: once raised, the error never drops without reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

endmodule

// File: rtl/mpx_dram.sv
module mpx_dram #(
  parameter int ROW_W     = 9,
  parameter int COL_W     = 9,
  parameter int DATA_W    = 8,
  parameter int RET_LIMIT = 64000,
  parameter int ADDR_W    = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              ret_err
);

  import mdr_pkg::*;

  localparam int ROW_BITS = DATA_W << COL_W;

  logic              ras_q, cas_q, we_q, oe_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] din_q;
  logic              ras_fall, cas_fall, we_fall;

  mdr_strobe_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .addr     (addr),
    .din      (dq_in),
    .ras_q    (ras_q),
    .cas_q    (cas_q),
    .we_q     (we_q),
    .oe_q     (oe_q),
    .addr_q   (addr_q),
    .din_q    (din_q),
    .ras_fall (ras_fall),
    .cas_fall (cas_fall),
    .we_fall  (we_fall)
  );

  bank_st_t         state_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] col_sel;
  logic             activate, load_en, wb_en, col_wr, drv_next;
  logic [ROW_BITS-1:0] arr_rdata, buf_row;
  logic [DATA_W-1:0]   rword;

  // Column from the address pins on the strobe edge, else the held one
  assign col_sel  = cas_fall ? addr_q[COL_W-1:0] : col_q;
  assign activate = (state_q == ST_IDLE) && ras_fall;
  assign load_en  = (state_q == ST_LOAD);
  assign wb_en    = (state_q == ST_OPEN) && ras_q;
  // Early write on the column edge, late write on the write-enable edge
  assign col_wr   = (state_q == ST_OPEN) && !ras_q &&
                    ((cas_fall && !we_q) || (we_fall && !cas_q));
  assign drv_next = (state_q == ST_OPEN) && !ras_q && !cas_q && !oe_q && we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      row_q   <= '0;
      col_q   <= '0;
    end else begin
      if (cas_fall && !ras_q) col_q <= addr_q[COL_W-1:0];
      unique case (state_q)
        ST_IDLE: if (ras_fall) begin
          row_q   <= addr_q[ROW_W-1:0];
          state_q <= ST_LOAD;
        end
        ST_LOAD: state_q <= ST_OPEN;
        ST_OPEN: if (ras_q) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  mdr_row_store #(.ROW_W(ROW_W), .ROW_BITS(ROW_BITS)) u_store (
    .clk     (clk),
    .wr_en   (wb_en),
    .wr_row  (row_q),
    .wr_data (buf_row),
    .rd_row  (addr_q[ROW_W-1:0]),
    .rd_data (arr_rdata)
  );

  mdr_row_buffer #(.COL_W(COL_W), .DATA_W(DATA_W)) u_rowbuf (
    .clk       (clk),
    .load_en   (load_en),
    .load_data (arr_rdata),
    .col_wr    (col_wr),
    .col       (col_sel),
    .wdata     (din_q),
    .rword     (rword),
    .row_data  (buf_row)
  );

  mdr_retention #(.ROW_W(ROW_W), .RET_LIMIT(RET_LIMIT)) u_ret (
    .clk     (clk),
    .rst     (rst),
    .clr_en  (activate),
    .clr_row (addr_q[ROW_W-1:0]),
    .err     (ret_err)
  );

  // Registered pad outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe  <= drv_next;
      dq_out <= drv_next ? rword : '0;
    end
  end

  // R6: the open row address holds for the whole page
  p_row_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN && $past(state_q) == ST_OPEN) |-> $stable(row_q));

  // R2: a row only becomes open after its array read was loaded
  p_open_after_load_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_OPEN && $past(state_q) != ST_OPEN) |-> $past(state_q) == ST_LOAD);

  // R7: write-back is a single-cycle event per row cycle
  p_wb_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> !wb_en);

  // R8: no pad drive while the bank stays closed
  p_no_drive_closed_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && $past(state_q) == ST_IDLE) |-> !dq_oe);

endmodule

// File: tb/mpx_dram_tb.sv
module mpx_dram_tb;

  localparam int RW  = 4;
  localparam int CW  = 4;
  localparam int DW  = 8;
  localparam int LIM = 4000;
  localparam int NR  = 1 << RW;
  localparam int NC  = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [RW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic          ret_err;

  always #5 clk = ~clk;

  mpx_dram #(.ROW_W(RW), .COL_W(CW), .DATA_W(DW), .RET_LIMIT(LIM)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .addr    (addr),
    .dq_in   (dq_in),
    .dq_out  (dq_out),
    .dq_oe   (dq_oe),
    .ret_err (ret_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] ref_mem [NR][NC];
  int cur_row = 0;

  logic [DW-1:0] exp_q[$];
  string         tag_q[$];
  event          rd_ev;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Scoreboard monitor: pops one expected word per read strobe
  initial begin
    forever begin
      @(rd_ev);
      begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(dq_oe === 1'b1 && dq_out === e, t, {dq_oe, dq_out}, {1'b1, e});
      end
    end
  end

  task automatic open_row(input int r);
    cur_row = r;
    addr = RW'(r);
    ras_n = 1'b0;
    step(4);
  endtask

  task automatic close_row();
    cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    ras_n = 1'b1;
    step(3);
  endtask

  // R4 early write
  task automatic early_wr(input int c, input logic [DW-1:0] d);
    addr = RW'(c);
    dq_in = d;
    we_n = 1'b0;
    step(1);
    cas_n = 1'b0;
    step(3);
    cas_n = 1'b1;
    we_n = 1'b1;
    step(2);
    ref_mem[cur_row][c] = d;
  endtask

  // R5 late write; pad must stay undriven while OE is high (R3)
  task automatic late_wr(input int c, input logic [DW-1:0] d);
    addr = RW'(c);
    cas_n = 1'b0;
    step(3);
    chk(dq_oe == 1'b0, "R3 no drive with OE high", dq_oe, 0);
    dq_in = d;
    we_n = 1'b0;
    step(3);
    we_n = 1'b1;
    cas_n = 1'b1;
    step(2);
    ref_mem[cur_row][c] = d;
  endtask

  // Early read: OE before CAS
  task automatic early_rd(input int c, input string tag);
    oe_n = 1'b0;
    addr = RW'(c);
    step(1);
    cas_n = 1'b0;
    step(3);
    exp_q.push_back(ref_mem[cur_row][c]);
    tag_q.push_back(tag);
    -> rd_ev;
    cas_n = 1'b1;
    oe_n = 1'b1;
    step(2);
    chk(dq_oe == 1'b0, "R3 release after CAS rise", dq_oe, 0);
  endtask

  // Late read: CAS before OE
  task automatic late_rd(input int c, input string tag);
    addr = RW'(c);
    cas_n = 1'b0;
    step(3);
    chk(dq_oe == 1'b0, "R3 late read waits for OE", dq_oe, 0);
    oe_n = 1'b0;
    step(3);
    exp_q.push_back(ref_mem[cur_row][c]);
    tag_q.push_back(tag);
    -> rd_ev;
    oe_n = 1'b1;
    cas_n = 1'b1;
    step(2);
  endtask

  // R8 refresh-only cycle with OE low
  task automatic refresh(input int r);
    bit drove;
    drove = 1'b0;
    addr = RW'(r);
    oe_n = 1'b0;
    ras_n = 1'b0;
    for (int k = 0; k < 6; k++) begin
      step(1);
      if (dq_oe) drove = 1'b1;
    end
    ras_n = 1'b1;
    oe_n = 1'b1;
    step(3);
    chk(!drove, "R8 refresh never drives", drove, 0);
  endtask

  task automatic sweep();
    for (int r = 0; r < NR; r++) refresh(r);
  endtask

  initial begin
    step(5);
    rst = 1'b0;
    step(2);
    chk(dq_oe == 1'b0, "R1 dq_oe after reset", dq_oe, 0);
    chk(ret_err == 1'b0, "R1 ret_err after reset", ret_err, 0);

    sweep();

    // R4/R6: page of early writes per row
    for (int r = 0; r < 4; r++) begin
      open_row(r);
      for (int c = 0; c < NC; c++) early_wr(c, DW'((r * 16 + c) ^ 8'h5A));
      close_row();
    end

    // R5: page of late writes
    open_row(6);
    for (int c = 0; c < NC; c++) late_wr(c, DW'(8'hA0 + c * 3));
    close_row();

    // R2/R6: page-mode early reads
    for (int r = 0; r < 4; r++) begin
      open_row(r);
      for (int c = 0; c < NC; c++) early_rd(c, "R2 early read");
      close_row();
    end

    // R3/R5: late reads of the late-written row
    open_row(6);
    for (int c = 0; c < NC; c++) late_rd(c, "R5 late read");
    close_row();

    // R6: mixed page
    open_row(2);
    early_wr(3, 8'hC3);
    early_rd(3, "R6 read after write in page");
    early_rd(4, "R6 neighbour column");
    late_wr(5, 8'h3C);
    late_rd(5, "R6 late write then read");
    close_row();

    open_row(1);
    early_rd(0, "R7 other row");
    close_row();

    // R7: write-back kept and untouched columns intact
    open_row(2);
    for (int c = 0; c < NC; c++) early_rd(c, "R7 write-back");
    close_row();

    // R8: refresh keeps contents
    refresh(2);
    refresh(6);
    open_row(2);
    early_rd(3, "R8 after refresh");
    close_row();
    open_row(6);
    late_rd(9, "R8 after refresh");
    close_row();

    // R9/R10 retention window
    sweep();
    chk(ret_err == 1'b0, "R9 refreshed in time", ret_err, 0);
    step(LIM - 200);
    chk(ret_err == 1'b0, "R9 just below limit", ret_err, 0);
    step(300);
    chk(ret_err == 1'b1, "R10 deadline missed", ret_err, 1);
    sweep();
    chk(ret_err == 1'b1, "R10 sticky after refresh", ret_err, 1);

    rst = 1'b1;
    step(2);
    rst = 1'b0;
    step(2);
    chk(ret_err == 1'b0, "R1 reset clears error", ret_err, 0);
    chk(dq_oe == 1'b0, "R1 reset pad idle", dq_oe, 0);

    step(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule